// File: doc/BRIEF.md
# DDR Rank Decode and Address Mapper

This block sits between the system bus and a DDR SDRAM command scheduler. Each request carries a byte address and a direction. Three boundary inputs place two memory ranks in the address space: a low and a high bound for the first rank, and a high bound for the second. The second rank starts on the byte right after the first rank ends. From these bounds the block picks the target rank and forms the offset inside that rank. It then splits the offset into row, bank and column fields. A mode input selects between a 256-column and a 512-column device layout.

A request that lands outside both ranks is still passed on to memory, so the scheduler always receives a well-defined command. The block raises an error pulse with that output and records the fault in a sticky status. The status holds the first faulting address and its direction, plus an overflow flag for any later fault. Software clears the status by writing one to a clear strobe.

Decode is registered, with one cycle of latency. The ready signal from the scheduler passes straight back to the bus, and the output stage advances only while that ready signal is high.

Top module: `ddr_rank_mapper`

## Requirements
- R1: With the mode fixed, an address in [rank0Lo, rank0Hi] selects rank 0 (mapRank=0). An address in (rank0Hi, rank1Hi] selects rank 1 (mapRank=1).
- R2: Both rank sizes are powers of two, and each rank starts on a multiple of its size. The in-rank offset is the address ANDed with (rank0Hi - rank0Lo) for rank 0, and with (rank1Hi - rank0Hi - 1) for rank 1.
- R3: When cfgCol512=0, the offset maps as column = {0, offset[9:2]}, bank = offset[11:10] and row = offset[12 +: ROW_W]. A 32-byte burst therefore covers 8 consecutive columns.
- R4: When cfgCol512=1, the offset maps as column = {offset[10], offset[9:2]}, bank = offset[12:11] and row = offset[13 +: ROW_W].
- R5: reqReady equals schedReady. When schedReady is 1, the outputs at a clock edge show the request presented before that edge, with mapValid = reqValid. When schedReady is 0, all map outputs hold their values.
- R6: An out-of-range request is still issued, with mapValid=1. In the same cycle mapErr=1 and mapRank=1, and the offset uses the rank 1 mask.
- R7: The first out-of-range request sets errValid. It captures errAddr and errWrite, and these update together with the mapped output.
- R8: An out-of-range request that arrives while errValid=1 sets errOverflow and leaves errAddr and errWrite unchanged.
- R9: csrClear=1 clears errValid and errOverflow at the next edge. If a fault is accepted in the same cycle, it is captured as a fresh first error with errOverflow=0.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Bus request valid |
| reqReady | output | 1 | Bus request ready (equals schedReady) |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqAddr | input | ADDR_W | Request byte address |
| schedReady | input | 1 | Scheduler accepts the mapped output |
| cfgRank0Lo | input | ADDR_W | Rank 0 lowest byte address |
| cfgRank0Hi | input | ADDR_W | Rank 0 highest byte address |
| cfgRank1Hi | input | ADDR_W | Rank 1 highest byte address |
| cfgCol512 | input | 1 | 1 = 512-column layout, 0 = 256-column layout |
| mapValid | output | 1 | Mapped command valid |
| mapWrite | output | 1 | Mapped command direction |
| mapRank | output | 1 | Rank select |
| mapRow | output | ROW_W | Row address |
| mapBank | output | 2 | Bank address |
| mapCol | output | 9 | Column address |
| mapErr | output | 1 | Out-of-range pulse, aligned with mapValid |
| csrClear | input | 1 | Write-one-to-clear strobe for the error status |
| errValid | output | 1 | Sticky error flag |
| errOverflow | output | 1 | A further fault arrived after the first |
| errWrite | output | 1 | Direction of the captured fault |
| errAddr | output | ADDR_W | Address of the captured fault |

## Verification
The assertions assume a static configuration. The rank bounds must describe power-of-two ranks that are aligned to their own size, and the bounds and the column mode must stay fixed while requests are in flight. The bench sets the bounds once after reset: two aligned 1 MB ranks. It changes cfgCol512 only between requests, on the falling edge and while the pipeline is idle. Stall tests keep the address and direction steady while schedReady is low, just as a real bus would hold a pending request.

// File: rtl/ddr_map_pkg.sv
package ddr_map_pkg;
  localparam int COL_W   = 9;
  localparam int BANK_W  = 2;
  localparam int BEAT_LO = 2;
  localparam int ROW_LO_NARROW = 12;
  localparam int ROW_LO_WIDE   = 13;

  typedef struct packed {
    logic advance;
    logic capture;
  } mapStrobe_t;
endpackage

// File: rtl/ddr_map_ctrl.sv
module ddr_map_ctrl
  import ddr_map_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       schedReady,
  input  logic       addrMiss,
  input  logic       csrClear,
  output mapStrobe_t strobe,
  output logic       errValid,
  output logic       errOverflow
);
  logic faultTaken;

  assign faultTaken     = reqValid && schedReady && addrMiss;
  assign strobe.advance = schedReady;
  assign strobe.capture = faultTaken && (!errValid || csrClear);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errValid    <= 1'b0;
      errOverflow <= 1'b0;
    end else if (csrClear) begin
      errValid    <= faultTaken;
      errOverflow <= 1'b0;
    end else begin
      errValid    <= errValid | faultTaken;
      errOverflow <= errOverflow | (faultTaken && errValid);
    end
  end

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !csrClear |=> errValid);
  p_ovf_needs_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    errOverflow |-> errValid);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    csrClear && !faultTaken |=> !errValid && !errOverflow);
  p_fresh_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    csrClear && faultTaken |=> errValid && !errOverflow);
endmodule

// File: rtl/ddr_map_dp.sv
module ddr_map_dp
  import ddr_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobe_t        strobe,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] cfgRank0Lo,
  input  logic [ADDR_W-1:0] cfgRank0Hi,
  input  logic [ADDR_W-1:0] cfgRank1Hi,
  input  logic              cfgCol512,
  output logic              addrMiss,
  output logic              mapValid,
  output logic              mapWrite,
  output logic              mapRank,
  output logic [ROW_W-1:0]  mapRow,
  output logic [BANK_W-1:0] mapBank,
  output logic [COL_W-1:0]  mapCol,
  output logic              mapErr,
  output logic              errWrite,
  output logic [ADDR_W-1:0] errAddr
);
  localparam int COL_LO_W = COL_W - 1;

  logic              inRank0, inRank1, rankSel;
  logic [ADDR_W-1:0] mask0, mask1, offset;
  logic [ROW_W-1:0]  rowNext;
  logic [BANK_W-1:0] bankNext;
  logic [COL_W-1:0]  colNext;
  logic              unusedOffset;

  assign inRank0  = (reqAddr >= cfgRank0Lo) && (reqAddr <= cfgRank0Hi);
  assign inRank1  = (reqAddr >  cfgRank0Hi) && (reqAddr <= cfgRank1Hi);
  assign addrMiss = !inRank0 && !inRank1;
  assign rankSel  = !inRank0;

  assign mask0  = cfgRank0Hi - cfgRank0Lo;
  assign mask1  = cfgRank1Hi - cfgRank0Hi - ADDR_W'(1);
  assign offset = reqAddr & (rankSel ? mask1 : mask0);
  assign unusedOffset = ^offset;

  always_comb begin
    if (cfgCol512) begin
      colNext  = {offset[BEAT_LO+COL_LO_W], offset[BEAT_LO +: COL_LO_W]};
      bankNext = offset[BEAT_LO+COL_LO_W+1 +: BANK_W];
      rowNext  = offset[ROW_LO_WIDE +: ROW_W];
    end else begin
      colNext  = {1'b0, offset[BEAT_LO +: COL_LO_W]};
      bankNext = offset[BEAT_LO+COL_LO_W +: BANK_W];
      rowNext  = offset[ROW_LO_NARROW +: ROW_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapValid <= 1'b0;
      mapWrite <= 1'b0;
      mapRank  <= 1'b0;
      mapRow   <= '0;
      mapBank  <= '0;
      mapCol   <= '0;
      mapErr   <= 1'b0;
    end else if (strobe.advance) begin
      mapValid <= reqValid;
      mapWrite <= reqWrite;
      mapRank  <= rankSel;
      mapRow   <= rowNext;
      mapBank  <= bankNext;
      mapCol   <= colNext;
      mapErr   <= reqValid && addrMiss;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errWrite <= 1'b0;
      errAddr  <= '0;
    end else if (strobe.capture) begin
      errWrite <= reqWrite;
      errAddr  <= reqAddr;
    end
  end

  p_err_issued_r6: assert property (@(posedge clk) disable iff (!rstN)
    mapErr |-> mapValid && mapRank);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.advance |=> $stable(mapValid) && $stable(mapErr) && $stable(mapCol));
endmodule

// File: rtl/ddr_rank_mapper.sv
module ddr_rank_mapper
  import ddr_map_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ROW_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              schedReady,
  input  logic [ADDR_W-1:0] cfgRank0Lo,
  input  logic [ADDR_W-1:0] cfgRank0Hi,
  input  logic [ADDR_W-1:0] cfgRank1Hi,
  input  logic              cfgCol512,
  output logic              mapValid,
  output logic              mapWrite,
  output logic              mapRank,
  output logic [ROW_W-1:0]  mapRow,
  output logic [1:0]        mapBank,
  output logic [8:0]        mapCol,
  output logic              mapErr,
  input  logic              csrClear,
  output logic              errValid,
  output logic              errOverflow,
  output logic              errWrite,
  output logic [ADDR_W-1:0] errAddr
);
  mapStrobe_t strobe;
  logic       addrMiss;

  assign reqReady = schedReady;

  ddr_map_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .schedReady(schedReady),
    .addrMiss(addrMiss), .csrClear(csrClear), .strobe(strobe),
    .errValid(errValid), .errOverflow(errOverflow)
  );

  ddr_map_dp #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .cfgRank0Lo(cfgRank0Lo),
    .cfgRank0Hi(cfgRank0Hi), .cfgRank1Hi(cfgRank1Hi), .cfgCol512(cfgCol512),
    .addrMiss(addrMiss), .mapValid(mapValid), .mapWrite(mapWrite),
    .mapRank(mapRank), .mapRow(mapRow), .mapBank(mapBank), .mapCol(mapCol),
    .mapErr(mapErr), .errWrite(errWrite), .errAddr(errAddr)
  );

  p_addr_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    errValid && !csrClear |=> $stable(errAddr) && $stable(errWrite));
  p_first_fault_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errValid) |-> mapErr);
endmodule

// File: tb/tb_ddr_rank_mapper.sv
module tb_ddr_rank_mapper;
  localparam int AW = 32;
  localparam int RW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, schedReady = 1'b1, csrClear = 1'b0;
  logic cfgCol512 = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [AW-1:0] cfgRank0Lo = 32'h0010_0000;
  logic [AW-1:0] cfgRank0Hi = 32'h001F_FFFF;
  logic [AW-1:0] cfgRank1Hi = 32'h002F_FFFF;
  logic reqReady, mapValid, mapWrite, mapRank, mapErr;
  logic errValid, errOverflow, errWrite;
  logic [RW-1:0] mapRow;
  logic [1:0] mapBank;
  logic [8:0] mapCol;
  logic [AW-1:0] errAddr;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ddr_rank_mapper #(.ADDR_W(AW), .ROW_W(RW)) dut (.*);

  typedef struct packed {
    logic [31:0] addr;
    logic        mode;
    logic        rank;
    logic [15:0] row;
    logic [1:0]  bank;
    logic [8:0]  col;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h0010_0000, 1'b0, 1'b0, 16'h0000, 2'd0, 9'h000},
    '{32'h0010_0020, 1'b0, 1'b0, 16'h0000, 2'd0, 9'h008},
    '{32'h0010_0C00, 1'b0, 1'b0, 16'h0000, 2'd3, 9'h000},
    '{32'h0010_1404, 1'b0, 1'b0, 16'h0001, 2'd1, 9'h001},
    '{32'h0020_0800, 1'b0, 1'b1, 16'h0000, 2'd2, 9'h000},
    '{32'h0010_0400, 1'b1, 1'b0, 16'h0000, 2'd0, 9'h100},
    '{32'h0010_0800, 1'b1, 1'b0, 16'h0000, 2'd1, 9'h000},
    '{32'h0010_2000, 1'b1, 1'b0, 16'h0001, 2'd0, 9'h000},
    '{32'h0020_1C3C, 1'b1, 1'b1, 16'h0000, 2'd3, 9'h10F},
    '{32'h001F_FFFC, 1'b0, 1'b0, 16'h00FF, 2'd3, 9'h0FF},
    '{32'h0020_0000, 1'b0, 1'b1, 16'h0000, 2'd0, 9'h000},
    '{32'h002F_FFFC, 1'b1, 1'b1, 16'h007F, 2'd3, 9'h1FF}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic wr);
    @(negedge clk);
    reqAddr = a; reqWrite = wr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic chkMap(input string req, input logic rank, input logic [15:0] row,
                        input logic [1:0] bank, input logic [8:0] col, input logic err);
    chk(req, "mapValid", 32'(mapValid), 32'd1);
    chk("R1", "mapRank", 32'(mapRank), 32'(rank));
    chk(req, "mapRow", 32'(mapRow), 32'(row));
    chk(req, "mapBank", 32'(mapBank), 32'(bank));
    chk(req, "mapCol", 32'(mapCol), 32'(col));
    chk("R6", "mapErr", 32'(mapErr), 32'(err));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "mapValid", 32'(mapValid), 0);
    chk("R10", "mapErr", 32'(mapErr), 0);
    chk("R10", "errValid", 32'(errValid), 0);
    chk("R10", "errAddr", errAddr, 0);
    chk("R10", "mapCol", 32'(mapCol), 0);
    rstN = 1'b1;

    // R1 R2 R3 R4: table walk
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      cfgCol512 = VECS[i].mode;
      issue(VECS[i].addr, i[0]);
      chkMap(VECS[i].mode ? "R4" : "R3", VECS[i].rank, VECS[i].row,
             VECS[i].bank, VECS[i].col, 1'b0);
      chk("R2", "mapWrite", 32'(mapWrite), 32'(i[0]));
      @(negedge clk);
      chk("R5", "mapValid drops", 32'(mapValid), 0);
    end
    chk("R7", "no fault logged for in-range", 32'(errValid), 0);

    // R5: stall holds outputs, ready follows scheduler
    cfgCol512 = 1'b0;
    @(negedge clk);
    schedReady = 1'b0; reqAddr = 32'h0010_0C00; reqWrite = 1'b1; reqValid = 1'b1;
    #1 chk("R5", "reqReady", 32'(reqReady), 0);
    @(negedge clk);
    chk("R5", "held mapValid", 32'(mapValid), 0);
    schedReady = 1'b1;
    #1 chk("R5", "reqReady", 32'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    chkMap("R5", 1'b0, 16'h0, 2'd3, 9'h000, 1'b0);

    // R6 R7: first fault above rank 1, write
    issue(32'h0030_1000, 1'b1);
    chkMap("R6", 1'b1, 16'h0001, 2'd0, 9'h000, 1'b1);
    chk("R7", "errValid", 32'(errValid), 1);
    chk("R7", "errAddr", errAddr, 32'h0030_1000);
    chk("R7", "errWrite", 32'(errWrite), 1);
    chk("R8", "errOverflow", 32'(errOverflow), 0);
    @(negedge clk);
    chk("R6", "mapErr pulse ends", 32'(mapErr), 0);
    chk("R7", "errValid sticky", 32'(errValid), 1);

    // R6 R8: second fault below rank 0, read
    issue(32'h000F_F000, 1'b0);
    chkMap("R6", 1'b1, 16'h00FF, 2'd0, 9'h000, 1'b1);
    chk("R8", "errOverflow", 32'(errOverflow), 1);
    chk("R8", "errAddr kept", errAddr, 32'h0030_1000);
    chk("R8", "errWrite kept", 32'(errWrite), 1);

    // R9: clear
    @(negedge clk);
    csrClear = 1'b1;
    @(negedge clk);
    csrClear = 1'b0;
    chk("R9", "errValid cleared", 32'(errValid), 0);
    chk("R9", "errOverflow cleared", 32'(errOverflow), 0);

    // R9: clear with a fault in the same cycle
    issue(32'h0000_0010, 1'b1);
    chk("R9", "errAddr first", errAddr, 32'h0000_0010);
    @(negedge clk);
    reqAddr = 32'h0040_0000; reqWrite = 1'b0; reqValid = 1'b1; csrClear = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; csrClear = 1'b0;
    chk("R9", "errValid fresh", 32'(errValid), 1);
    chk("R9", "errAddr fresh", errAddr, 32'h0040_0000);
    chk("R9", "errWrite fresh", 32'(errWrite), 0);
    chk("R9", "errOverflow fresh", 32'(errOverflow), 0);
    chkMap("R6", 1'b1, 16'h0000, 2'd0, 9'h000, 1'b1);

    // R7: in-range request leaves status alone
    issue(32'h0010_0020, 1'b1);
    chk("R7", "mapErr in range", 32'(mapErr), 0);
    chk("R7", "errAddr unchanged", errAddr, 32'h0040_0000);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule